// File: doc/BRIEF.md
# Windowed Command and Status Register File

This block is the host-facing control point of a network adapter. The host writes 16-bit command words to one port. Each word carries an opcode and an argument. The host reads back a 16-bit status word that reports three things: the currently selected register window, a busy flag for commands that take several cycles, and eight latched event bits. A separate output shows the selected window, so that the window-dependent register decoding next to this block can use it.

The block decodes the following commands: window selection, event acknowledge, interrupt mask load, read-visibility mask load, software interrupt request, receive and transmit enable, disable and reset, and global reset. The datapaths that would act on these commands are not part of the block. It drives level enables and one-cycle reset pulses toward them, and it takes one-cycle event pulses back from them.

An interrupt output is raised while any unmasked event is latched. The reset commands occupy the block for a programmable number of cycles. During that time the host sees the busy flag set and must wait, and any word written while busy is dropped.

Top module: `nic_ctl_regfile`

## Requirements
- R1: After reset the status word is 0x0000, the window output is 0, the interrupt output is low, and both the receive and transmit enables are low.
- R2: A command word carries its opcode in bits 15:11 and its argument in bits 10:0. A word is taken only in a cycle where the write strobe is high and the busy flag is clear. Opcodes 2, 6, 7, 8 and 16 to 31 change no output and no state.
- R3: Opcode 1 loads the window from argument bits 2:0. From the next cycle, the window appears on the window output and in status bits 15:13. Argument bits 10:3 are ignored.
- R4: Status bits 7:0 are the latched events: bit 0 interrupt latch, 1 adapter failure, 2 TX complete, 3 TX available, 4 RX complete, 5 RX early, 6 interrupt requested, 7 update statistics. Event input bits 1 to 5 and 7 set the matching latch one cycle after the pulse, and the latch holds until acknowledged. Event input bits 0 and 6 have no effect.
- R5: Opcode 13 clears every latched event whose argument bit 7:0 is set and leaves the others. If an event pulse arrives in the same cycle as its acknowledge, the event stays set.
- R6: Opcode 14 loads the interrupt mask from argument bits 7:0. The interrupt output is high exactly while some latched event among bits 7:1 has its mask bit set. Mask bit 0 has no effect.
- R7: In the cycle after the interrupt output rises, the interrupt latch event (bit 0) becomes set.
- R8: Opcode 15 loads the read mask from argument bits 7:0. A status bit in 7:0 reads as zero while its read-mask bit is clear, and the underlying latch is kept. The read mask is 0x00 after reset.
- R9: Opcode 12 sets the interrupt-requested event (bit 6).
- R10: Opcodes 4 and 3 set and clear the receive enable, and opcodes 9 and 10 set and clear the transmit enable. Opcode 5 clears the receive enable and pulses the receive reset output for one cycle. Opcode 11 does the same for the transmit side.
- R11: Status bit 12 (busy) goes high in the cycle after an accepted reset command. It stays high for PRST_CYCLES cycles after opcode 5 or 11, and for GRST_CYCLES cycles after opcode 0.
- R12: Command words written while busy is high are dropped.
- R13: Opcode 0 pulses the global reset output for one cycle and returns the window, both masks, all latched events and both enables to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_data_i | input | 16 | Command word: opcode 15:11, argument 10:0 |
| hw_evt_i | input | 8 | One-cycle event pulses from the datapaths, indexed like status bits 7:0 |
| status_o | output | 16 | Window 15:13, busy 12, zero 11:8, visible events 7:0 |
| window_o | output | 3 | Selected register window |
| irq_o | output | 1 | Interrupt request |
| rx_en_o | output | 1 | Receive enable |
| tx_en_o | output | 1 | Transmit enable |
| rx_rst_o | output | 1 | One-cycle receive reset pulse |
| tx_rst_o | output | 1 | One-cycle transmit reset pulse |
| glob_rst_o | output | 1 | One-cycle global reset pulse |

## Verification
Window selection is tried with all eight window values, and each is paired with non-zero upper argument bits so that a decoder reading too many bits is exposed. The event and mask paths are swept one bit at a time: single-bit acknowledges against a full latch set, single-bit interrupt masks with every other event already pending, and single-bit read masks over a fixed latch pattern. These sweeps separate a wrong bit position, a wrong polarity and a mask applied to the wrong stage. Every unused opcode is sent with an all-ones argument against a non-reset state. Reset commands are issued back to back with other commands so that the exact busy length and the dropping of words during busy can both be measured.

// File: rtl/nrf_pkg.sv
package nrf_pkg;

  localparam int WORD_W = 16;
  localparam int OP_W   = 5;
  localparam int ARG_W  = WORD_W - OP_W;
  localparam int EV_W   = 8;
  localparam int WIN_W  = 3;

  // status word layout
  localparam int BUSY_BIT = 12;
  localparam int WIN_LSB  = WORD_W - WIN_W;
  localparam int PAD_W    = WIN_LSB - 1 - EV_W;

  // event positions that are generated inside the block
  localparam int EV_LATCH = 0;
  localparam int EV_REQ   = 6;

  typedef enum logic [OP_W-1:0] {
    OP_GLOBAL_RST = 5'd0,
    OP_WIN_SEL    = 5'd1,
    OP_RX_OFF     = 5'd3,
    OP_RX_ON      = 5'd4,
    OP_RX_RST     = 5'd5,
    OP_TX_ON      = 5'd9,
    OP_TX_OFF     = 5'd10,
    OP_TX_RST     = 5'd11,
    OP_RAISE      = 5'd12,
    OP_ACK        = 5'd13,
    OP_IMASK      = 5'd14,
    OP_RMASK      = 5'd15
  } op_e;

  typedef struct packed {
    logic glob_rst;
    logic win_sel;
    logic rx_off;
    logic rx_on;
    logic rx_rst;
    logic tx_on;
    logic tx_off;
    logic tx_rst;
    logic raise;
    logic ack;
    logic imask;
    logic rmask;
  } cmd_dec_t;

endpackage

// File: rtl/nrf_rst_sync.sv
module nrf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/nrf_decode.sv
module nrf_decode
  import nrf_pkg::*;
(
  input  logic            accept_i,
  input  logic [OP_W-1:0] op_i,
  output cmd_dec_t        dec_o
);

  always_comb begin
    dec_o = '0;
    if (accept_i) begin
      case (op_i)
        OP_GLOBAL_RST: dec_o.glob_rst = 1'b1;
        OP_WIN_SEL:    dec_o.win_sel  = 1'b1;
        OP_RX_OFF:     dec_o.rx_off   = 1'b1;
        OP_RX_ON:      dec_o.rx_on    = 1'b1;
        OP_RX_RST:     dec_o.rx_rst   = 1'b1;
        OP_TX_ON:      dec_o.tx_on    = 1'b1;
        OP_TX_OFF:     dec_o.tx_off   = 1'b1;
        OP_TX_RST:     dec_o.tx_rst   = 1'b1;
        OP_RAISE:      dec_o.raise    = 1'b1;
        OP_ACK:        dec_o.ack      = 1'b1;
        OP_IMASK:      dec_o.imask    = 1'b1;
        OP_RMASK:      dec_o.rmask    = 1'b1;
        default:       dec_o          = '0;
      endcase
    end
  end

endmodule

// File: rtl/nrf_busy_timer.sv
module nrf_busy_timer #(
  parameter int LONG_CYC  = 32,
  parameter int SHORT_CYC = 6,
  localparam int MAX_CYC  = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC,
  localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_long_i,
  input  logic start_short_i,
  output logic busy_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (start_long_i) begin
      cnt_d = CNT_W'(LONG_CYC);
    end else if (start_short_i) begin
      cnt_d = CNT_W'(SHORT_CYC);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/nrf_event_bank.sv
module nrf_event_bank
  import nrf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_all_i,
  input  logic [EV_W-1:0] hw_evt_i,
  input  logic            raise_i,
  input  logic            ack_i,
  input  logic [EV_W-1:0] ack_bits_i,
  input  logic [EV_W-1:0] imask_i,
  output logic [EV_W-1:0] lat_o,
  output logic            irq_o
);

  logic [EV_W-1:0] lat_q, lat_d;
  logic            cond, cond_q, cond_d;
  logic            unused_evt;

  // mask bit 0 never contributes, so the latch cannot hold itself up
  assign cond   = |(lat_q[EV_W-1:1] & imask_i[EV_W-1:1]);
  assign cond_d = clr_all_i ? 1'b0 : cond;

  assign unused_evt = ^{hw_evt_i[EV_LATCH], hw_evt_i[EV_REQ]};

  for (genvar i = 0; i < EV_W; i++) begin : g_ev
    logic set_b;
    logic clr_b;
    if (i == EV_LATCH) begin : g_latch
      assign set_b = cond & ~cond_q;
    end else if (i == EV_REQ) begin : g_req
      assign set_b = raise_i;
    end else begin : g_hw
      assign set_b = hw_evt_i[i];
    end
    assign clr_b    = ack_i & ack_bits_i[i];
    assign lat_d[i] = clr_all_i ? 1'b0 :
                      set_b     ? 1'b1 :
                      clr_b     ? 1'b0 : lat_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      lat_q  <= lat_d;
      cond_q <= cond_d;
    end
  end

  assign lat_o = lat_q;
  assign irq_o = cond;

endmodule

// File: rtl/nic_ctl_regfile.sv
module nic_ctl_regfile
  import nrf_pkg::*;
#(
  parameter int GRST_CYCLES = 32,
  parameter int PRST_CYCLES = 6
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              cmd_wr_i,
  input  logic [WORD_W-1:0] cmd_data_i,
  input  logic [EV_W-1:0]   hw_evt_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WIN_W-1:0]  window_o,
  output logic              irq_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              rx_rst_o,
  output logic              tx_rst_o,
  output logic              glob_rst_o
);

  logic             rst_n;
  logic             busy;
  logic             accept;
  logic [OP_W-1:0]  op;
  logic [ARG_W-1:0] arg;
  cmd_dec_t         dec;
  logic             unused_arg;

  nrf_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  assign op         = cmd_data_i[WORD_W-1 -: OP_W];
  assign arg        = cmd_data_i[ARG_W-1:0];
  assign accept     = cmd_wr_i & ~busy;
  assign unused_arg = ^arg[ARG_W-1:EV_W];

  nrf_decode u_dec (
    .accept_i (accept),
    .op_i     (op),
    .dec_o    (dec)
  );

  nrf_busy_timer #(
    .LONG_CYC  (GRST_CYCLES),
    .SHORT_CYC (PRST_CYCLES)
  ) u_busy (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .start_long_i  (dec.glob_rst),
    .start_short_i (dec.rx_rst | dec.tx_rst),
    .busy_o        (busy)
  );

  logic [WIN_W-1:0] window_q, window_d;
  logic [EV_W-1:0]  imask_q, imask_d;
  logic [EV_W-1:0]  rmask_q, rmask_d;
  logic             rx_en_q, rx_en_d;
  logic             tx_en_q, tx_en_d;
  logic             rx_p_q, tx_p_q, g_p_q;
  logic [EV_W-1:0]  lat_q;

  nrf_event_bank u_ev (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .clr_all_i  (dec.glob_rst),
    .hw_evt_i   (hw_evt_i),
    .raise_i    (dec.raise),
    .ack_i      (dec.ack),
    .ack_bits_i (arg[EV_W-1:0]),
    .imask_i    (imask_q),
    .lat_o      (lat_q),
    .irq_o      (irq_o)
  );

  // next state of the command-controlled registers
  always_comb begin
    window_d = window_q;
    imask_d  = imask_q;
    rmask_d  = rmask_q;
    rx_en_d  = rx_en_q;
    tx_en_d  = tx_en_q;
    if (dec.glob_rst) begin
      window_d = '0;
      imask_d  = '0;
      rmask_d  = '0;
      rx_en_d  = 1'b0;
      tx_en_d  = 1'b0;
    end else begin
      if (dec.win_sel) window_d = arg[WIN_W-1:0];
      if (dec.imask)   imask_d  = arg[EV_W-1:0];
      if (dec.rmask)   rmask_d  = arg[EV_W-1:0];
      if (dec.rx_on)   rx_en_d  = 1'b1;
      if (dec.rx_off || dec.rx_rst) rx_en_d = 1'b0;
      if (dec.tx_on)   tx_en_d  = 1'b1;
      if (dec.tx_off || dec.tx_rst) tx_en_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      window_q <= '0;
      imask_q  <= '0;
      rmask_q  <= '0;
      rx_en_q  <= 1'b0;
      tx_en_q  <= 1'b0;
    end else if (accept) begin
      window_q <= window_d;
      imask_q  <= imask_d;
      rmask_q  <= rmask_d;
      rx_en_q  <= rx_en_d;
      tx_en_q  <= tx_en_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rx_p_q <= 1'b0;
      tx_p_q <= 1'b0;
      g_p_q  <= 1'b0;
    end else begin
      rx_p_q <= dec.rx_rst;
      tx_p_q <= dec.tx_rst;
      g_p_q  <= dec.glob_rst;
    end
  end

  assign status_o   = {window_q, busy, {PAD_W{1'b0}}, lat_q & rmask_q};
  assign window_o   = window_q;
  assign rx_en_o    = rx_en_q;
  assign tx_en_o    = tx_en_q;
  assign rx_rst_o   = rx_p_q;
  assign tx_rst_o   = tx_p_q;
  assign glob_rst_o = g_p_q;

endmodule

// File: rtl/nrf_checker.sv
module nrf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [15:0] cmd_data,
  input logic [15:0] status,
  input logic [2:0]  window,
  input logic        irq,
  input logic [7:0]  lat,
  input logic        rx_en,
  input logic        rx_rst
);

  logic taken;
  assign taken = cmd_wr && !status[12];

  assert_win_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    taken && cmd_data[15:11] == 5'd1 |=> window == $past(cmd_data[2:0]));

  assert_busy_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && status[12] |=> $stable(window) && $stable(rx_en));

  assert_grst_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    taken && cmd_data[15:11] == 5'd0 |=> status[12] && window == 3'd0);

  assert_latch_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) && !(taken && cmd_data[15:11] == 5'd0) |=> lat[0]);

  assert_rx_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |-> !rx_en);

  assert_rx_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> !rx_rst);

endmodule

bind nic_ctl_regfile nrf_checker u_chk (
  .clk      (clk_i),
  .rst_n    (rst_n),
  .cmd_wr   (cmd_wr_i),
  .cmd_data (cmd_data_i),
  .status   (status_o),
  .window   (window_o),
  .irq      (irq_o),
  .lat      (lat_q),
  .rx_en    (rx_en_o),
  .rx_rst   (rx_rst_o)
);

// File: tb/nic_ctl_regfile_test.sv
`timescale 1ns/1ps
module nic_ctl_regfile_test;

  localparam int C_GRST = 12;
  localparam int C_PRST = 3;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_data = '0;
  logic [7:0]  hw_evt = '0;
  logic [15:0] status;
  logic [2:0]  window;
  logic        irq, rx_en, tx_en, rx_rst, tx_rst, glob_rst;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nic_ctl_regfile #(.GRST_CYCLES(C_GRST), .PRST_CYCLES(C_PRST)) uut (
    .clk_i(clk), .arst_ni(arst_n), .cmd_wr_i(cmd_wr), .cmd_data_i(cmd_data),
    .hw_evt_i(hw_evt), .status_o(status), .window_o(window), .irq_o(irq),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .rx_rst_o(rx_rst), .tx_rst_o(tx_rst),
    .glob_rst_o(glob_rst)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic issue(input logic [4:0] op, input logic [10:0] arg);
    cmd_wr = 1'b1;
    cmd_data = {op, arg};
    @(posedge clk);
    @(negedge clk);
    cmd_wr = 1'b0;
    cmd_data = '0;
  endtask

  task automatic pulse(input logic [7:0] ev);
    hw_evt = ev;
    @(posedge clk);
    @(negedge clk);
    hw_evt = '0;
  endtask

  task automatic wait_idle();
    while (status[12]) @(negedge clk);
  endtask

  function automatic int busy_len_left();
    return 0;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_lat;
    int n;
    repeat (3) step();
    arst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 status", status, 16'h0000);
    chk("R1 window", {13'd0, window}, 16'd0);
    chk("R1 irq/rx/tx", {13'd0, irq, rx_en, tx_en}, 16'd0);

    // R8 read mask starts at zero: events hidden
    pulse(8'h04);
    chk("R8 hidden after reset", status, 16'h0000);
    issue(5'd15, 11'h0FF);
    chk("R8 visible after mask load", status, 16'h0004);
    issue(5'd13, 11'h0FF);

    // R3 window sweep with junk upper argument bits
    for (int w = 0; w < 8; w++) begin
      issue(5'd1, {8'hA5, w[2:0]});
      chk("R3 window_o", {13'd0, window}, 16'(w));
      chk("R3 status window", {13'd0, status[15:13]}, 16'(w));
    end
    issue(5'd1, 11'd0);

    // R4 each hardware event bit latches and accumulates
    exp_lat = '0;
    for (int i = 1; i < 8; i++) begin
      if (i != 6) begin
        pulse(8'(1 << i));
        exp_lat[i] = 1'b1;
        chk("R4 latch accumulate", status, {8'h00, exp_lat});
      end
    end
    step();
    chk("R4 held", status, 16'h00BE);
    pulse(8'h41);
    chk("R4 input bits 0 and 6 ignored", status, 16'h00BE);

    // R5 single-bit acknowledges
    for (int i = 0; i < 8; i++) begin
      pulse(8'hBE);
      issue(5'd13, 11'(1 << i));
      chk("R5 ack one bit", status, {8'h00, 8'hBE & ~8'(1 << i)});
      issue(5'd13, 11'h0FF);
    end
    chk("R5 ack all", status, 16'h0000);
    hw_evt = 8'h04;
    issue(5'd13, 11'h004);
    hw_evt = '0;
    chk("R5 event wins over ack", status, 16'h0004);
    issue(5'd13, 11'h004);

    // R9 software request
    issue(5'd12, 11'h7FF);
    chk("R9 raise sets bit 6", status, 16'h0040);
    issue(5'd13, 11'h040);

    // R6 / R7 single-bit interrupt masks
    for (int i = 1; i < 8; i++) begin
      issue(5'd14, 11'd0);
      issue(5'd13, 11'h0FF);
      issue(5'd14, 11'(1 << i));
      pulse(8'hBE & ~8'(1 << i));
      chk("R6 other events no irq", {15'd0, irq}, 16'd0);
      if (i == 6) issue(5'd12, 11'd0);
      else pulse(8'(1 << i));
      chk("R6 irq on masked event", {15'd0, irq}, 16'd1);
      chk("R7 latch not yet", {15'd0, status[0]}, 16'd0);
      step();
      chk("R7 latch set next cycle", {15'd0, status[0]}, 16'd1);
    end
    issue(5'd14, 11'h001);
    chk("R6 mask bit 0 no effect", {15'd0, irq}, 16'd0);
    issue(5'd14, 11'd0);
    issue(5'd13, 11'h0FF);

    // R8 single-bit read masks
    pulse(8'hBE);
    for (int j = 0; j < 8; j++) begin
      issue(5'd15, 11'(1 << j));
      chk("R8 read mask bit", status, {8'h00, 8'hBE & 8'(1 << j)});
    end
    issue(5'd15, 11'h0FF);
    chk("R8 latches kept", status, 16'h00BE);
    issue(5'd13, 11'h0FF);

    // R10 enables and resets, R11 busy length
    issue(5'd4, 11'h3FF);
    chk("R10 rx on", {15'd0, rx_en}, 16'd1);
    issue(5'd3, 11'd0);
    chk("R10 rx off", {15'd0, rx_en}, 16'd0);
    issue(5'd9, 11'h155);
    chk("R10 tx on", {15'd0, tx_en}, 16'd1);
    issue(5'd10, 11'd0);
    chk("R10 tx off", {15'd0, tx_en}, 16'd0);
    issue(5'd4, 11'd0);
    issue(5'd5, 11'd0);
    chk("R10 rx reset pulse/en", {14'd0, rx_rst, rx_en}, 16'b10);
    n = 0;
    while (status[12]) begin n++; step(); end
    chk("R11 rx reset busy length", 16'(n), 16'(C_PRST));
    chk("R10 rx pulse single", {15'd0, rx_rst}, 16'd0);
    issue(5'd9, 11'd0);
    issue(5'd11, 11'd0);
    chk("R10 tx reset pulse/en", {14'd0, tx_rst, tx_en}, 16'b10);
    n = 0;
    while (status[12]) begin n++; step(); end
    chk("R11 tx reset busy length", 16'(n), 16'(C_PRST));

    // R12 words during busy are dropped
    issue(5'd1, 11'd2);
    issue(5'd5, 11'd0);
    issue(5'd1, 11'd5);
    issue(5'd4, 11'd0);
    chk("R12 window kept", {13'd0, window}, 16'd2);
    chk("R12 rx kept off", {15'd0, rx_en}, 16'd0);
    wait_idle();

    // R2 unused opcodes change nothing
    issue(5'd1, 11'd3);
    issue(5'd4, 11'd0);
    issue(5'd9, 11'd0);
    issue(5'd14, 11'h010);
    pulse(8'h90);
    for (int op = 2; op < 32; op++) begin
      if (op == 2 || (op >= 6 && op <= 8) || op >= 16) begin
        issue(5'(op), 11'h7FF);
        chk("R2 unused op status", status, 16'h6091);
        chk("R2 unused op outputs",
            {9'd0, window, irq, rx_en, tx_en, rx_rst | tx_rst | glob_rst}, {9'd0, 3'd3, 4'b1110});
      end
    end

    // R13 global reset
    issue(5'd0, 11'h7FF);
    chk("R13 global pulse", {15'd0, glob_rst}, 16'd1);
    chk("R13 status after global", status, 16'h1000);
    n = 0;
    while (status[12]) begin n++; step(); end
    chk("R11 global busy length", 16'(n), 16'(C_GRST));
    chk("R13 outputs restored", {12'd0, window, irq}, 16'd0);
    chk("R13 enables restored", {14'd0, rx_en, tx_en}, 16'd0);
    pulse(8'h10);
    chk("R13 read mask restored", status, 16'h0000);
    chk("R13 irq mask restored", {15'd0, irq}, 16'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule